// File: doc/BRIEF.md
# Conditional Branch and Skip Unit

This block advances the program counter of a small 8-bit processor core for the control-flow and flag-handling part of its instruction set. On each step request it takes the 16-bit instruction word and the value of the register that instruction addresses. It then computes the next program counter for status-conditional relative branches and for register-bit skips. It also sets or clears single status bits, moves a register bit into the transfer flag (T), and moves T back into a register bit. A halt word stops all further stepping.

The program counter, the 8-bit status register and the halted flag are held inside the block and update on the clock edge that accepts a step. The register address field is always shown on `reg_addr_o` so that a register file can supply `reg_val_i` in the same cycle. A bit load returns the modified register value on `reg_wr_data_o`, qualified by `reg_wr_en_o`, during that same cycle. Instruction fetch and arithmetic are handled elsewhere. The program counter is 16 bits by default and wraps modulo 2^16.

Top module: `branch_skip_unit`

## Requirements
- R1: After reset, pc_o is 0x0000, sreg_o is 0x00, halted_o is 0 and reg_wr_en_o is 0.
- R2: A word with bits [15:11] = 11110 is a branch. Bit [10] is the polarity: 0 branches when the tested status bit is 1, and 1 branches when it is 0. Bits [9:3] are a signed word offset: values 64..127 mean value − 128. Bits [2:0] select the status bit, in the order C=0, Z=1, N=2, V=3, S=4, H=5, T=6, I=7. A taken branch loads pc + 1 + offset.
- R3: A branch whose condition is not met loads pc + 1 and leaves sreg_o unchanged.
- R4: Every program counter update wraps modulo 2^16, for both forward and backward offsets.
- R5: A word with [15:10] = 111111 and [3] = 0 is a skip. Bit [9] is the required bit value, [8:4] is the register (always shown on reg_addr_o), and [2:0] is the bit index. When reg_val_i[index] equals the required value, pc advances by 2, otherwise by 1.
- R6: A word with [15:9] = 1111101 and [3] = 0 copies reg_val_i[[2:0]] into status bit 6 (T). It leaves the other status bits unchanged and advances pc by 1.
- R7: A word with [15:9] = 1111100 and [3] = 0 asserts reg_wr_en_o during the accepting cycle. reg_wr_data_o equals reg_val_i with bit [2:0] replaced by T. sreg_o is unchanged and pc advances by 1.
- R8: A word with [15:8] = 0x94 and [3:0] = 1000 forces status bit [6:4] to 1 when [7] = 0, or to 0 when [7] = 1. No other status bit changes and pc advances by 1.
- R9: The word 0x9598 advances pc by 1 and sets halted_o in the same update.
- R10: halted_o stays 1 until reset. While halted, a step request changes neither pc_o nor sreg_o, and reg_wr_en_o stays 0.
- R11: While step_i is 0, pc_o, sreg_o and halted_o keep their values whatever the instruction input carries.
- R12: Any other word, including skip or bit-transfer words with [3] = 1 and flag words with [3:0] ≠ 1000, advances pc by 1. It leaves sreg_o unchanged and does not assert reg_wr_en_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_i | input | 1 | Execute the presented instruction on this edge |
| instr_i | input | 16 | Instruction word |
| reg_val_i | input | DATA_W | Value of the register selected by reg_addr_o |
| reg_addr_o | output | 5 | Register field of the instruction |
| reg_wr_en_o | output | 1 | Bit-load write strobe |
| reg_wr_data_o | output | DATA_W | Register value with the loaded bit |
| pc_o | output | PC_W | Program counter |
| sreg_o | output | 8 | Status register |
| halted_o | output | 1 | Stepping stopped by the halt word |

## Verification
The halt word advances the program counter and raises the halted flag in the same update. The bench issues the halt word and checks both effects together. It then presents flag, branch and bit-load words with step_i held high, and judges them by an unchanged pc_o and sreg_o and a silent reg_wr_en_o. A bit load combines a register writeback with a program counter advance in one cycle. Its write strobe and data are sampled before the edge, and the pc and the unchanged status byte are sampled after it. Branch conditions are swept over every status bit and both polarities under several status patterns, and over all 128 offsets, with wrap-around crossings in both directions.

// File: rtl/bsu_pkg.sv
package bsu_pkg;

   localparam int INSTR_W = 16;
   localparam int SREG_W  = 8;
   localparam int OFF_W   = 7;
   localparam int IDX_W   = 3;
   localparam int RSEL_W  = 5;
   localparam int T_POS   = 6;

   localparam logic [INSTR_W-1:0] HALT_WORD = 16'h9598;

   typedef enum logic [2:0] {
      OPK_NONE,
      OPK_BRANCH,
      OPK_SKIP,
      OPK_TSTORE,
      OPK_TLOAD,
      OPK_FLAG,
      OPK_HALT
   } op_kind_e;

endpackage

// File: rtl/bsu_decode.sv
module bsu_decode
   import bsu_pkg::*;
(
   input  logic [INSTR_W-1:0] instr,
   output op_kind_e           kind,
   output logic               pol,
   output logic [OFF_W-1:0]   offset,
   output logic [IDX_W-1:0]   idx,
   output logic               want,
   output logic [RSEL_W-1:0]  rsel
);

   always_comb begin
      kind   = OPK_NONE;
      pol    = instr[10];
      offset = instr[9:3];
      rsel   = instr[8:4];
      idx    = instr[2:0];
      want   = instr[9];
      if (instr[15:11] == 5'b11110) begin
         kind = OPK_BRANCH;
      end else if (instr[15:10] == 6'b111111 && !instr[3]) begin
         kind = OPK_SKIP;
      end else if (instr[15:10] == 6'b111110 && !instr[3]) begin
         kind = instr[9] ? OPK_TSTORE : OPK_TLOAD;
      end else if (instr[15:8] == 8'h94 && instr[3:0] == 4'b1000) begin
         kind = OPK_FLAG;
         idx  = instr[6:4];
         want = ~instr[7];
      end else if (instr == HALT_WORD) begin
         kind = OPK_HALT;
      end
   end

endmodule

// File: rtl/bsu_cond.sv
module bsu_cond
   import bsu_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [SREG_W-1:0] sreg,
   input  logic [DATA_W-1:0] reg_val,
   input  op_kind_e          kind,
   input  logic              pol,
   input  logic [IDX_W-1:0]  idx,
   input  logic              want,
   output logic              br_taken,
   output logic              skip_hit
);

   logic flag_bit;
   logic reg_bit;

   assign flag_bit = sreg[idx];
   assign reg_bit  = reg_val[idx];

   // polarity 0: jump on a set bit; polarity 1: jump on a clear bit
   assign br_taken = (kind == OPK_BRANCH) && (flag_bit != pol);
   assign skip_hit = (kind == OPK_SKIP) && (reg_bit == want);

endmodule

// File: rtl/bsu_pc_next.sv
module bsu_pc_next
   import bsu_pkg::*;
#(
   parameter int PC_W        = 16,
   parameter int ADDER_STYLE = 0
) (
   input  logic [PC_W-1:0]  pc,
   input  logic             br_taken,
   input  logic             skip_hit,
   input  logic [OFF_W-1:0] offset,
   output logic [PC_W-1:0]  pc_next
);

   localparam int EXT_W = PC_W - OFF_W;

   logic [PC_W-1:0] off_ext;
   assign off_ext = {{EXT_W{offset[OFF_W-1]}}, offset};

   generate
      if (ADDER_STYLE == 0) begin : g_shared
         // one carry chain, increment chosen ahead of it
         logic [PC_W-1:0] incr;
         always_comb begin
            if (br_taken)      incr = off_ext + PC_W'(1);
            else if (skip_hit) incr = PC_W'(2);
            else               incr = PC_W'(1);
         end
         assign pc_next = pc + incr;
      end else begin : g_parallel
         // three sums in parallel, mux at the end
         logic [PC_W-1:0] seq_pc;
         logic [PC_W-1:0] skp_pc;
         logic [PC_W-1:0] jmp_pc;
         assign seq_pc  = pc + PC_W'(1);
         assign skp_pc  = pc + PC_W'(2);
         assign jmp_pc  = seq_pc + off_ext;
         assign pc_next = br_taken ? jmp_pc : (skip_hit ? skp_pc : seq_pc);
      end
   endgenerate

endmodule

// File: rtl/bsu_flag_unit.sv
module bsu_flag_unit
   import bsu_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [SREG_W-1:0] sreg,
   input  logic [DATA_W-1:0] reg_val,
   input  op_kind_e          kind,
   input  logic [IDX_W-1:0]  idx,
   input  logic              want,
   output logic [SREG_W-1:0] sreg_next,
   output logic [DATA_W-1:0] wr_data
);

   logic sel_reg_bit;
   logic is_flag;
   logic is_store;

   assign sel_reg_bit = reg_val[idx];
   assign is_flag     = (kind == OPK_FLAG);
   assign is_store    = (kind == OPK_TSTORE);

   generate
      for (genvar s = 0; s < SREG_W; s++) begin : g_sbit
         logic hit_flag;
         assign hit_flag = is_flag && (idx == IDX_W'(s));
         if (s == T_POS) begin : g_tbit
            assign sreg_next[s] = hit_flag ? want :
                                  (is_store ? sel_reg_bit : sreg[s]);
         end else begin : g_plain
            assign sreg_next[s] = hit_flag ? want : sreg[s];
         end
      end
      for (genvar d = 0; d < DATA_W; d++) begin : g_dbit
         assign wr_data[d] = (idx == IDX_W'(d)) ? sreg[T_POS] : reg_val[d];
      end
   endgenerate

endmodule

// File: rtl/branch_skip_unit.sv
module branch_skip_unit
   import bsu_pkg::*;
#(
   parameter int              PC_W        = 16,
   parameter int              DATA_W      = 8,
   parameter int              ADDER_STYLE = 0,
   parameter logic [PC_W-1:0] RESET_PC    = '0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                step_i,
   input  logic [INSTR_W-1:0]  instr_i,
   input  logic [DATA_W-1:0]   reg_val_i,
   output logic [RSEL_W-1:0]   reg_addr_o,
   output logic                reg_wr_en_o,
   output logic [DATA_W-1:0]   reg_wr_data_o,
   output logic [PC_W-1:0]     pc_o,
   output logic [SREG_W-1:0]   sreg_o,
   output logic                halted_o
);

   generate
      if (PC_W < OFF_W + 1 || PC_W > 32) begin : g_bad_pc_w
         $error("PC_W must lie between 8 and 32");
      end
      if (DATA_W != (1 << IDX_W)) begin : g_bad_data_w
         $error("DATA_W must match the 3-bit bit-index field");
      end
      if (ADDER_STYLE != 0 && ADDER_STYLE != 1) begin : g_bad_style
         $error("ADDER_STYLE must be 0 or 1");
      end
   endgenerate

   op_kind_e           kind;
   logic               pol;
   logic [OFF_W-1:0]   offset;
   logic [IDX_W-1:0]   idx;
   logic               want;
   logic               br_taken;
   logic               skip_hit;
   logic [PC_W-1:0]    pc_q;
   logic [PC_W-1:0]    pc_next;
   logic [SREG_W-1:0]  sreg_q;
   logic [SREG_W-1:0]  sreg_next;
   logic               halted_q;
   logic               exec;

   assign exec = step_i && !halted_q;

   bsu_decode u_decode (
      .instr  (instr_i),
      .kind   (kind),
      .pol    (pol),
      .offset (offset),
      .idx    (idx),
      .want   (want),
      .rsel   (reg_addr_o)
   );

   bsu_cond #(.DATA_W(DATA_W)) u_cond (
      .sreg     (sreg_q),
      .reg_val  (reg_val_i),
      .kind     (kind),
      .pol      (pol),
      .idx      (idx),
      .want     (want),
      .br_taken (br_taken),
      .skip_hit (skip_hit)
   );

   bsu_pc_next #(.PC_W(PC_W), .ADDER_STYLE(ADDER_STYLE)) u_pc_next (
      .pc       (pc_q),
      .br_taken (br_taken),
      .skip_hit (skip_hit),
      .offset   (offset),
      .pc_next  (pc_next)
   );

   bsu_flag_unit #(.DATA_W(DATA_W)) u_flags (
      .sreg      (sreg_q),
      .reg_val   (reg_val_i),
      .kind      (kind),
      .idx       (idx),
      .want      (want),
      .sreg_next (sreg_next),
      .wr_data   (reg_wr_data_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_q     <= RESET_PC;
         sreg_q   <= '0;
         halted_q <= 1'b0;
      end else if (exec) begin
         pc_q     <= pc_next;
         sreg_q   <= sreg_next;
         halted_q <= (kind == OPK_HALT);
      end
   end

   assign reg_wr_en_o = exec && (kind == OPK_TLOAD);
   assign pc_o        = pc_q;
   assign sreg_o      = sreg_q;
   assign halted_o    = halted_q;

endmodule

// File: rtl/bsu_checker.sv
module bsu_checker #(
   parameter int PC_W   = 16,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              step_i,
   input logic [15:0]       instr_i,
   input logic [DATA_W-1:0] reg_val_i,
   input logic              reg_wr_en_o,
   input logic [DATA_W-1:0] reg_wr_data_o,
   input logic [PC_W-1:0]   pc_o,
   input logic [7:0]        sreg_o,
   input logic              halted_o
);

   p_halt_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      halted_o |=> halted_o);

   p_halt_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
      halted_o |=> ($stable(pc_o) && $stable(sreg_o)));

   p_halt_no_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
      halted_o |-> !reg_wr_en_o);

   p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !step_i |=> ($stable(pc_o) && $stable(sreg_o) && $stable(halted_o)));

   p_halt_word_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !halted_o && instr_i == 16'h9598)
      |=> (halted_o && pc_o == $past(pc_o) + 1'b1));

   p_skip_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !halted_o && instr_i[15:10] == 6'b111111 && !instr_i[3])
      |=> (pc_o == $past(pc_o) + 2'd1 || pc_o == $past(pc_o) + 2'd2));

   p_flag_one_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !halted_o && instr_i[15:8] == 8'h94 && instr_i[3:0] == 4'h8)
      |=> ($countones(sreg_o ^ $past(sreg_o)) <= 1));

   p_load_one_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_en_o |-> ($countones(reg_wr_data_o ^ reg_val_i) <= 1));

   p_load_keeps_sreg_r7: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_en_o |=> $stable(sreg_o));

endmodule

bind branch_skip_unit bsu_checker #(.PC_W(PC_W), .DATA_W(DATA_W)) u_bsu_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .step_i        (step_i),
   .instr_i       (instr_i),
   .reg_val_i     (reg_val_i),
   .reg_wr_en_o   (reg_wr_en_o),
   .reg_wr_data_o (reg_wr_data_o),
   .pc_o          (pc_o),
   .sreg_o        (sreg_o),
   .halted_o      (halted_o)
);

// File: tb/branch_skip_unit_tb.sv
`timescale 1ns/1ps
module branch_skip_unit_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        step_i = 1'b0;
   logic [15:0] instr_i = '0;
   logic [7:0]  reg_val_i = '0;
   logic [4:0]  reg_addr_o;
   logic        reg_wr_en_o;
   logic [7:0]  reg_wr_data_o;
   logic [15:0] pc_o;
   logic [7:0]  sreg_o;
   logic        halted_o;

   always #4 clk = ~clk;

   branch_skip_unit u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .step_i        (step_i),
      .instr_i       (instr_i),
      .reg_val_i     (reg_val_i),
      .reg_addr_o    (reg_addr_o),
      .reg_wr_en_o   (reg_wr_en_o),
      .reg_wr_data_o (reg_wr_data_o),
      .pc_o          (pc_o),
      .sreg_o        (sreg_o),
      .halted_o      (halted_o)
   );

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   logic [15:0] m_pc;
   logic [7:0]  m_sreg;
   logic        m_halt;

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] f_br(input logic pol, input logic [6:0] off,
                                        input logic [2:0] b);
      return {5'b11110, pol, off, b};
   endfunction

   function automatic logic [15:0] f_skip(input logic req, input logic [4:0] r,
                                          input logic [2:0] b);
      return {6'b111111, req, r, 1'b0, b};
   endfunction

   function automatic logic [15:0] f_tbit(input logic store, input logic [4:0] r,
                                          input logic [2:0] b);
      return {6'b111110, store, r, 1'b0, b};
   endfunction

   function automatic logic [15:0] f_flag(input logic clr, input logic [2:0] b);
      return {8'h94, clr, b, 4'b1000};
   endfunction

   task automatic apply_reset();
      step_i = 1'b0;
      rst_n  = 1'b0;
      repeat (2) @(negedge clk);
      rst_n  = 1'b1;
      m_pc   = 16'h0000;
      m_sreg = 8'h00;
      m_halt = 1'b0;
   endtask

   // drive at a falling edge, judge the combinational outputs, then the registers
   task automatic exec(input logic [15:0] ins, input logic [7:0] rv, input string req);
      logic       exp_wr;
      logic [7:0] exp_data;
      int         b;
      int         soff;
      exp_wr   = 1'b0;
      exp_data = rv;
      b        = int'(ins[2:0]);
      instr_i   = ins;
      reg_val_i = rv;
      step_i    = 1'b1;
      #1;
      if (!m_halt) begin
         if (ins[15:11] == 5'b11110) begin
            soff = int'(ins[9:3]);
            if (soff > 63) soff = soff - 128;
            if (m_sreg[b] != ins[10]) m_pc = m_pc + 16'(1 + soff);
            else                      m_pc = m_pc + 16'd1;
         end else if (ins[15:10] == 6'b111111 && !ins[3]) begin
            m_pc = m_pc + ((rv[b] == ins[9]) ? 16'd2 : 16'd1);
         end else if (ins[15:9] == 7'b1111101 && !ins[3]) begin
            m_sreg[6] = rv[b];
            m_pc = m_pc + 16'd1;
         end else if (ins[15:9] == 7'b1111100 && !ins[3]) begin
            exp_wr = 1'b1;
            exp_data[b] = m_sreg[6];
            m_pc = m_pc + 16'd1;
         end else if (ins[15:8] == 8'h94 && ins[3:0] == 4'h8) begin
            m_sreg[ins[6:4]] = ~ins[7];
            m_pc = m_pc + 16'd1;
         end else if (ins == 16'h9598) begin
            m_halt = 1'b1;
            m_pc = m_pc + 16'd1;
         end else begin
            m_pc = m_pc + 16'd1;
         end
      end
      check(req, "reg_addr", 32'(reg_addr_o), 32'(ins[8:4]));
      check(req, "reg_wr_en", 32'(reg_wr_en_o), 32'(exp_wr));
      if (exp_wr) check(req, "reg_wr_data", 32'(reg_wr_data_o), 32'(exp_data));
      @(negedge clk);
      step_i = 1'b0;
      check(req, "pc", 32'(pc_o), 32'(m_pc));
      check(req, "sreg", 32'(sreg_o), 32'(m_sreg));
      check(req, "halted", 32'(halted_o), 32'(m_halt));
   endtask

   task automatic program_sreg(input logic [7:0] v, input string req);
      for (int i = 0; i < 8; i++) exec(f_flag(~v[i], 3'(i)), 8'h00, req);
   endtask

   task automatic idle_cycles(input int n);
      for (int i = 0; i < n; i++) begin
         instr_i   = (i % 2 == 0) ? 16'h9598 : f_flag(1'b0, 3'(i));
         reg_val_i = 8'(i * 29);
         step_i    = 1'b0;
         @(negedge clk);
         check("R11", "pc idle", 32'(pc_o), 32'(m_pc));
         check("R11", "sreg idle", 32'(sreg_o), 32'(m_sreg));
         check("R11", "halted idle", 32'(halted_o), 32'(m_halt));
      end
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : main
      logic [7:0] pats [4];
      pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5; pats[3] = 8'h5A;

      apply_reset();
      check("R1", "pc reset", 32'(pc_o), 32'h0000);
      check("R1", "sreg reset", 32'(sreg_o), 32'h00);
      check("R1", "halted reset", 32'(halted_o), 32'h0);
      check("R1", "wr_en reset", 32'(reg_wr_en_o), 32'h0);

      // R4: backward wrap through zero, then forward wrap back
      exec(f_flag(1'b0, 3'd1), 8'h00, "R8");
      exec(f_br(1'b0, 7'h40, 3'd1), 8'h00, "R4");
      check("R4", "pc literal backward", 32'(pc_o), 32'hFFC2);
      exec(f_br(1'b0, 7'd63, 3'd1), 8'h00, "R4");
      check("R4", "pc literal forward", 32'(pc_o), 32'h0002);

      // R8: set and clear each status bit in turn
      for (int i = 0; i < 8; i++) exec(f_flag(1'b0, 3'(i)), 8'h00, "R8");
      for (int i = 7; i >= 0; i -= 2) exec(f_flag(1'b1, 3'(i)), 8'h00, "R8");
      check("R8", "sreg literal", 32'(sreg_o), 32'h55);

      // R2 / R3: every bit and polarity under several status patterns
      for (int p = 0; p < 4; p++) begin
         program_sreg(pats[p], "R8");
         for (int b = 0; b < 8; b++) begin
            for (int pol = 0; pol < 2; pol++) begin
               exec(f_br(1'(pol), 7'((b * 19 + pol * 45 + p * 11) % 128), 3'(b)),
                    8'h00, (pats[p][b] != 1'(pol)) ? "R2" : "R3");
            end
         end
      end

      // R2: full offset sweep with a taken condition (Z set, polarity 0)
      exec(f_flag(1'b0, 3'd1), 8'h00, "R8");
      for (int k = 0; k < 128; k++) exec(f_br(1'b0, 7'(k), 3'd1), 8'h00, "R2");
      // R3: same offsets with the condition not met
      for (int k = 0; k < 128; k += 9) exec(f_br(1'b1, 7'(k), 3'd1), 8'h00, "R3");

      // R5: skips over values, bits and required polarity
      for (int v = 0; v < 256; v += 37) begin
         for (int b = 0; b < 8; b++) begin
            exec(f_skip(1'b0, 5'(v % 32), 3'(b)), 8'(v), "R5");
            exec(f_skip(1'b1, 5'(b + 3), 3'(b)), 8'(v), "R5");
         end
      end

      // R6: bit store into T
      for (int b = 0; b < 8; b++) begin
         exec(f_tbit(1'b1, 5'd9, 3'(b)), 8'h96, "R6");
         exec(f_tbit(1'b1, 5'd17, 3'(b)), 8'h69, "R6");
      end

      // R7: bit load from T with T both 1 and 0
      for (int b = 0; b < 8; b++) begin
         exec(f_flag(1'b0, 3'd6), 8'h00, "R8");
         exec(f_tbit(1'b0, 5'd4, 3'(b)), 8'h00, "R7");
         exec(f_flag(1'b1, 3'd6), 8'h00, "R8");
         exec(f_tbit(1'b0, 5'd30, 3'(b)), 8'hFF, "R7");
      end

      // R12: words outside the recognised forms
      exec(16'h0000, 8'hFF, "R12");
      exec(16'h1234, 8'h0F, "R12");
      exec({6'b111111, 1'b1, 5'd3, 1'b1, 3'd2}, 8'hFF, "R12");
      exec({6'b111110, 1'b0, 5'd3, 1'b1, 3'd5}, 8'h00, "R12");
      exec({6'b111110, 1'b1, 5'd3, 1'b1, 3'd6}, 8'hFF, "R12");
      exec({8'h94, 1'b0, 3'd2, 4'b1001}, 8'h00, "R12");

      // R11: no step, nothing moves
      idle_cycles(6);

      // R9 / R10: halt and the frozen state that follows
      exec(16'h9598, 8'h00, "R9");
      check("R9", "halted literal", 32'(halted_o), 32'h1);
      exec(f_flag(1'b0, 3'd0), 8'h00, "R10");
      exec(f_flag(1'b1, 3'd6), 8'h00, "R10");
      exec(f_br(1'b0, 7'd5, 3'd1), 8'h00, "R10");
      exec(f_skip(1'b1, 5'd1, 3'd0), 8'hFF, "R10");
      exec(f_tbit(1'b0, 5'd2, 3'd3), 8'h00, "R10");
      exec(16'h9598, 8'h00, "R10");
      idle_cycles(3);

      apply_reset();
      check("R1", "pc after second reset", 32'(pc_o), 32'h0000);
      check("R1", "halted after second reset", 32'(halted_o), 32'h0);
      check("R1", "sreg after second reset", 32'(sreg_o), 32'h00);
      exec(16'h0000, 8'h00, "R12");

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule